// File: doc/BRIEF.md
# Round-per-cycle 128-bit ARX block encryption core

This block encrypts one 128-bit data block under a 128-bit key with a lightweight add-rotate-xor cipher. It completes one full round in each clock cycle and runs 24 rounds. A single-cycle start request, taken while the core is idle, captures the plaintext and the key. The core then reports busy for the 24 round cycles and pulses done for one cycle. The ciphertext stays on its output until the next accepted start.

Each round performs the key-schedule update and the data round together in one combinational step. The four round constants come from a four-register ring. On every round each register takes its neighbour's value rotated left by one bit, so the head register always holds the current constant at the rotation that the round needs. The other three constants are that head value rotated by one, two and three bits, which is done in wiring alone.

Top module: `arx_enc_core`

## Requirements
- R1: After `rst_n` is sampled low at a clock edge, `busy_o` and `done_o` are 0 and `ct_o` is all zeros.
- R2: A `start_i` sampled high while `busy_o` is 0 captures `pt_i` and `key_i`, and `busy_o` is 1 from the next cycle. Word n of every 128-bit port occupies bits [32n+31:32n].
- R3: `busy_o` stays high for exactly 24 cycles after the accepting edge. `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again.
- R4: With key words T0..T3 and state words X0..X3, each round i (0..23) first updates T0←ROL1(T0+K0), T1←ROL3(T1+K1), T2←ROL6(T2+K2) and T3←ROL11(T3+K3), with sums modulo 2^32. It then sets X0←ROL9((X0^RK0)+(X1^RK1)), X1←ROR5((X1^RK2)+(X2^RK3)), X2←ROR3((X2^RK4)+(X3^RK5)) and X3←old X0. All rounds are identical, and `ct_o` on the done cycle is the final state.
- R5: The constants are D0=0xC3EFE9DB, D1=0x44626B02, D2=0x79E27C8A and D3=0x78DF30EC. In round i, Kj = ROL(i+j)(D[i mod 4]).
- R6: The round key words RK0..RK5 are the freshly updated key words T0, T1, T2, T1, T3 and T1.
- R7: A `start_i` sampled while `busy_o` is 1 is ignored. It changes neither the timing nor the ciphertext of the block in flight.
- R8: While idle with no start, `ct_o` holds the last ciphertext, or zero after reset.
- R9: A start sampled at the edge that ends the done cycle is accepted, which gives back-to-back blocks 25 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| pt_i | input | 128 | Plaintext, four 32-bit words |
| key_i | input | 128 | Key, four 32-bit words |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ct_o | output | 128 | Ciphertext, held while idle |

## Verification
Two situations put two functions into the same cycle. In the first, completion and a new acceptance meet: the bench raises start during the done cycle, so the pulse and the capture of the next block share one edge. The bench then expects busy in the following cycle and a correct ciphertext 25 cycles later. In the second, the last round and a spurious start meet: start is driven with different data during the final round cycle and in a middle round. The cycle model expects busy to fall on time and the ciphertext to match the original inputs.

// File: rtl/arx_enc_pkg.sv
// Package: word types, rotation helpers and cipher constants for the ARX core.
// Assumes 32-bit words and four words per block and per key.
package arx_enc_pkg;
    localparam int WORD_W = 32;
    localparam int NWORDS = 4;
    localparam int BLK_W  = WORD_W * NWORDS;

    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [NWORDS-1:0][WORD_W-1:0] quad_t;

    // Left rotation by a constant amount.
    function automatic word_t rol(word_t v, int unsigned n);
        int unsigned s;
        s = n % WORD_W;
        if (s == 0) return v;
        return (v << s) | (v >> (WORD_W - s));
    endfunction

    // Right rotation expressed as a left rotation.
    function automatic word_t ror(word_t v, int unsigned n);
        return rol(v, WORD_W - (n % WORD_W));
    endfunction

    // Seed constant k of the constant ring.
    function automatic word_t delta(int unsigned k);
        case (k % 4)
            0:       return 32'hC3EFE9DB;
            1:       return 32'h44626B02;
            2:       return 32'h79E27C8A;
            default: return 32'h78DF30EC;
        endcase
    endfunction

    // Final rotation applied to key word j in each schedule step.
    function automatic int unsigned key_rot(int unsigned j);
        case (j)
            0:       return 1;
            1:       return 3;
            2:       return 6;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/arx_const_ring.sv
// Constant ring: NC registers seeded on load. On each step every register
// takes its neighbour rotated left by one, so slot 0 holds the current
// round constant. rc_o[k] is slot 0 rotated left by k (wiring only).
// Assumes load_i and step_i are never both needed (load wins).
module arx_const_ring
    import arx_enc_pkg::*;
#(
    parameter int NC = NWORDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic                       step_i,
    output logic [NC-1:0][WORD_W-1:0]  rc_o
);
    word_t ring_q [NC];

    for (genvar k = 0; k < NC; k++) begin : g_slot
        // Seed, advance-and-rotate, or hold one ring slot.
        always_ff @(posedge clk) begin
            if (!rst_n)      ring_q[k] <= '0;
            else if (load_i) ring_q[k] <= delta(k);
            else if (step_i) ring_q[k] <= rol(ring_q[(k + 1) % NC], 1);
        end
        // Per-word constant for this round.
        assign rc_o[k] = rol(ring_q[0], k);
    end

    // R5
    ring_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ring_q[0] == delta(0)) && (ring_q[NC-1] == delta(NC-1)));
endmodule

// File: rtl/arx_key_step.sv
// Key schedule step: adds each key word to its round constant and rotates
// the sum by the word's fixed amount. Purely combinational.
module arx_key_step
    import arx_enc_pkg::*;
(
    input  quad_t key_i,
    input  quad_t rc_i,
    output quad_t key_o
);
    for (genvar j = 0; j < NWORDS; j++) begin : g_word
        // One word of the next key state.
        assign key_o[j] = rol(key_i[j] + rc_i[j], key_rot(j));
    end
endmodule

// File: rtl/arx_round.sv
// Data round: mixes the state with the six round-key words taken from the
// freshly updated key (T0,T1,T2,T1,T3,T1). Purely combinational.
module arx_round
    import arx_enc_pkg::*;
(
    input  quad_t st_i,
    input  quad_t key_i,
    output quad_t st_o
);
    word_t rk [6];
    word_t s0, s1, s2;

    // Expand the key words into the six round-key words.
    always_comb begin
        rk[0] = key_i[0];
        rk[1] = key_i[1];
        rk[2] = key_i[2];
        rk[3] = key_i[1];
        rk[4] = key_i[3];
        rk[5] = key_i[1];
    end

    // Three xor-add lanes, their rotations, and the word shuffle.
    always_comb begin
        s0 = (st_i[0] ^ rk[0]) + (st_i[1] ^ rk[1]);
        s1 = (st_i[1] ^ rk[2]) + (st_i[2] ^ rk[3]);
        s2 = (st_i[2] ^ rk[4]) + (st_i[3] ^ rk[5]);
        st_o[0] = rol(s0, 9);
        st_o[1] = ror(s1, 5);
        st_o[2] = ror(s2, 3);
        st_o[3] = st_i[0];
    end
endmodule

// File: rtl/arx_enc_core.sv
// Top: round-per-cycle ARX encryption core. Captures plaintext and key on a
// start taken while idle, runs ROUNDS rounds, pulses done, and holds the
// ciphertext until the next accepted start. Synchronous active-low reset.
module arx_enc_core
    import arx_enc_pkg::*;
#(
    parameter int ROUNDS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] pt_i,
    input  logic [BLK_W-1:0] key_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [BLK_W-1:0] ct_o
);
    localparam int              CNT_W = $clog2(ROUNDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    quad_t            st_q, key_q, rc, key_nx, st_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q, load;

    assign load = start_i && !busy_q;

    arx_const_ring #(.NC(NWORDS)) u_ring (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(busy_q), .rc_o(rc)
    );
    arx_key_step u_key (.key_i(key_q), .rc_i(rc), .key_o(key_nx));
    arx_round    u_rnd (.st_i(st_q), .key_i(key_nx), .st_o(st_nx));

    // State register: load plaintext or take the round result.
    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= '0;
        else if (load)   st_q <= pt_i;
        else if (busy_q) st_q <= st_nx;
    end

    // Key register: load key or take the scheduled key.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (load)   key_q <= key_i;
        else if (busy_q) key_q <= key_nx;
    end

    // Round counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign ct_o   = st_q;

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && ct_o == $past(pt_i)));
    // R3
    busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != LAST) |=> busy_o);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(busy_o));
    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
    // R8
    ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(ct_o));
endmodule

// File: tb/arx_enc_core_tb.sv
module arx_enc_core_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] pt_i = '0, key_i = '0;
    logic         busy_o, done_o;
    logic [127:0] ct_o;

    int checks = 0, failures = 0;
    bit chk_en = 1'b0;

    always #4 clk = ~clk;

    arx_enc_core u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pt_i(pt_i), .key_i(key_i),
        .busy_o(busy_o), .done_o(done_o), .ct_o(ct_o)
    );

    function automatic logic [31:0] brol(logic [31:0] v, int n);
        int s = n % 32;
        if (s == 0) return v;
        return (v << s) | (v >> (32 - s));
    endfunction

    // Behavioural cipher model from the requirement equations.
    function automatic logic [127:0] ref_enc(logic [127:0] p, logic [127:0] k);
        logic [31:0] x[4], t[4], nx[4], d[4];
        int ra[4];
        d  = '{32'hC3EFE9DB, 32'h44626B02, 32'h79E27C8A, 32'h78DF30EC};
        ra = '{1, 3, 6, 11};
        for (int j = 0; j < 4; j++) begin
            x[j] = p[32*j +: 32];
            t[j] = k[32*j +: 32];
        end
        for (int i = 0; i < 24; i++) begin
            for (int j = 0; j < 4; j++) t[j] = brol(t[j] + brol(d[i % 4], i + j), ra[j]);
            nx[0] = brol((x[0] ^ t[0]) + (x[1] ^ t[1]), 9);
            nx[1] = brol((x[1] ^ t[2]) + (x[2] ^ t[1]), 27);
            nx[2] = brol((x[2] ^ t[3]) + (x[3] ^ t[1]), 29);
            nx[3] = x[0];
            x = nx;
        end
        return {x[3], x[2], x[1], x[0]};
    endfunction

    // Cycle model state.
    bit           m_busy, m_done;
    int           m_cnt;
    logic [127:0] m_ct, m_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_ct = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == 23) begin m_busy = 0; m_done = 1; m_ct = m_pend; end
                else m_cnt++;
            end else if (start_i) begin
                m_busy = 1; m_cnt = 0; m_pend = ref_enc(pt_i, key_i);
            end
        end
    end

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            check(busy_o == m_busy, "R2 R3 R7 busy", 128'(busy_o), 128'(m_busy));
            check(done_o == m_done, "R3 R7 done", 128'(done_o), 128'(m_done));
            if (m_done) check(ct_o == m_ct, "R4 R5 R6 ciphertext", ct_o, m_ct);
            else if (!m_busy) check(ct_o == m_ct, "R8 held output", ct_o, m_ct);
        end
    end

    // One block; inject = spurious starts in a middle and in the last round.
    task automatic run_one(logic [127:0] p, logic [127:0] k, bit inject, bit b2b);
        @(negedge clk);
        start_i = 1; pt_i = p; key_i = k;
        @(negedge clk);
        start_i = 0; pt_i = {$urandom, $urandom, $urandom, $urandom};
        key_i = {$urandom, $urandom, $urandom, $urandom};
        if (b2b) check(busy_o == 1'b1, "R9 back-to-back accept", 128'(busy_o), 128'(1));
        else     check(busy_o == 1'b1, "R2 start accepted", 128'(busy_o), 128'(1));
        for (int j = 1; j < 24; j++) begin
            @(negedge clk);
            start_i = inject && (j == 10 || j == 23);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0, "R1 reset flags", 128'({busy_o, done_o}), 128'(0));
        check(ct_o == '0, "R1 reset ciphertext", ct_o, '0);
        rst_n = 1;
        chk_en = 1;
        @(negedge clk);
        run_one('0, '0, 0, 0);
        for (int n = 0; n < 60; n++) begin
            bit b2b = (n % 3 == 1);
            if (!b2b) begin
                @(negedge clk);
                start_i = 0;
                repeat ($urandom_range(0, 3)) @(negedge clk);
            end
            run_one({$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom, $urandom}, (n % 4 == 2), b2b);
        end
        @(negedge clk);
        start_i = 0;
        repeat (5) @(negedge clk);
        check(ct_o == m_ct && !busy_o, "R8 final hold", ct_o, m_ct);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule